// File: doc/BRIEF.md
# Slice Corner-Turn Shuffler

This block sits between two eight-point butterfly passes of a 64-point transform that is split as 8 x 8. A frame arrives as eight slices, one per cycle. Each slice is eight complex points wide, and slice `i` holds the points with indices `i, i+8, ..., i+56`. The block stores the frame and sends it back out in transposed order. On the first output cycle, each output lane carries the first point of a different input slice, so the second butterfly pass sees columns where the first pass saw rows.

Two banks take turns. One bank is filled row by row while the other is drained column by column, so frames can follow each other with no idle cycle between them. There is no back-pressure: the output runs at exactly the input rate. A frame start flag marks slice 0. If a start arrives in the middle of a frame, the partial frame is dropped and a new frame begins in the same bank.

Each point is 8 bits, made of a signed 4-bit real part in the upper nibble and a signed 4-bit imaginary part in the lower nibble. The block moves points as opaque words and never changes their bits. The lane count must be a power of two.

Top module: `slice_corner_turn`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a complete eight-slice frame has been accepted.
- R2: Lane `k` occupies bits `[8k+7:8k]` of both buses. On read cycle `j` (0..7) of a frame, output lane `k` equals input lane `j` of slice `k` of that frame, bit for bit.
- R3: A frame whose slice 0 is presented in cycle `P` gives `out_valid` high in cycles `P+8` through `P+15`, with no gap, and low again afterwards unless another frame follows.
- R4: Frames presented back to back, each start directly after the previous slice 7, come out as one unbroken run of `out_valid`, with every frame's data in order.
- R5: `in_valid` with `in_start` low, while no frame is in progress, is ignored and produces no output.
- R6: `in_start` during a partial frame discards the partial frame and opens a new frame at slice 0. Only the new frame is output, eight cycles after its start.
- R7: A cycle with `in_valid` low inside a frame abandons that frame. Slices that follow without `in_start` are ignored, and the next started frame is output correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A slice is present on `in_slice` |
| in_start | input | 1 | The present slice is slice 0 of a new frame |
| in_slice | input | 64 | Eight points; lane `l` in bits `[8l+7:8l]` |
| out_valid | output | 1 | A transposed column is present on `out_col` |
| out_col | output | 64 | Eight points of one column; lane `k` from slice `k` |

## Verification
The hardest case to reach is the bank handover: a bank fills on the very cycle the reader is finishing the other bank. This happens only when frames arrive with no idle cycle between them. The bench drives three frames back to back and checks that the output run is unbroken and that each frame's columns are correct. The restart and gap scenarios leave stale rows in a bank and then reuse it. Their checks show that the stale rows never reach the output.

// File: rtl/slice_ct_pkg.sv
package slice_ct_pkg;
  parameter int CT_LANES  = 8;
  parameter int CT_PART_W = 4;
  parameter int CT_BANKS  = 2;
endpackage

// File: rtl/ct_bank.sv
module ct_bank
  import slice_ct_pkg::*;
#(
  parameter  int LANES = CT_LANES,
  parameter  int PT_W  = 2 * CT_PART_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int BUS_W = LANES * PT_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_row,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_col,
  output logic [BUS_W-1:0] rd_data
);
  // Data storage carries no reset: contents are only read after a full write.
  logic [BUS_W-1:0] row_q [LANES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      row_q[wr_row] <= wr_data;
    end
  end

  // Column read: output lane k takes point rd_col of stored row k.
  for (genvar k = 0; k < LANES; k++) begin : g_col
    assign rd_data[k*PT_W +: PT_W] = row_q[k][rd_col*PT_W +: PT_W];
  end
endmodule

// File: rtl/ct_writer.sv
module ct_writer
  import slice_ct_pkg::*;
#(
  parameter  int LANES = CT_LANES,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_row,
  output logic             wr_bank,
  output logic             fill
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic             busy_q, busy_n;
  logic [IDX_W-1:0] cnt_q, cnt_n;
  logic             bank_q, bank_n;
  logic             accept;

  always_comb begin
    accept = in_valid && (in_start || busy_q);
    wr_row = in_start ? '0 : cnt_q;
    fill   = accept && (wr_row == LAST);
    busy_n = accept && !fill;
    cnt_n  = busy_n ? wr_row + 1'b1 : '0;
    bank_n = fill ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      bank_q <= bank_n;
    end
  end

  assign wr_en   = accept;
  assign wr_bank = bank_q;

  // Rows land in strict sequence; any nonzero row follows its predecessor.
  assert_row_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_row != '0) |-> ($past(wr_en) && wr_row == IDX_W'($past(wr_row) + 1'b1)));

  // A non-start slice right after an idle cycle never opens a frame.
  assert_orphan_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && !$past(in_valid)) |-> !wr_en);

  // A gap abandons the frame: the next non-start slice is not written.
  assert_gap_abandons_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(fill) && !in_valid) |=> !(wr_en && !in_start));
endmodule

// File: rtl/ct_reader.sv
module ct_reader
  import slice_ct_pkg::*;
#(
  parameter  int LANES = CT_LANES,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic             fill_bank,
  output logic             rd_active,
  output logic [IDX_W-1:0] rd_col,
  output logic             rd_bank
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic             act_q, act_n;
  logic [IDX_W-1:0] col_q, col_n;
  logic             bank_q, bank_n;

  always_comb begin
    act_n  = act_q;
    col_n  = col_q;
    bank_n = bank_q;
    if (fill) begin
      act_n  = 1'b1;
      col_n  = '0;
      bank_n = fill_bank;
    end else if (act_q) begin
      if (col_q == LAST) begin
        act_n = 1'b0;
        col_n = '0;
      end else begin
        col_n = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      col_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      col_q  <= col_n;
      bank_q <= bank_n;
    end
  end

  assign rd_active = act_q;
  assign rd_col    = col_q;
  assign rd_bank   = bank_q;

  // A drain run only ends after the last column has been shown.
  assert_full_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_active) |-> ($past(rd_col) == LAST));

  // Mid-run, the bank being drained never changes.
  assert_bank_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && $past(rd_col) != LAST) |-> $stable(rd_bank));
endmodule

// File: rtl/slice_corner_turn.sv
module slice_corner_turn
  import slice_ct_pkg::*;
#(
  parameter  int LANES  = CT_LANES,
  parameter  int PART_W = CT_PART_W,
  localparam int PT_W   = 2 * PART_W,
  localparam int IDX_W  = $clog2(LANES),
  localparam int BUS_W  = LANES * PT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [BUS_W-1:0] in_slice,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_col
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic             wr_en, wr_bank, fill;
  logic [IDX_W-1:0] wr_row, rd_col;
  logic             rd_bank;
  logic [BUS_W-1:0] bank_rd [CT_BANKS];

  ct_writer #(.LANES(LANES)) u_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_bank  (wr_bank),
    .fill     (fill)
  );

  for (genvar b = 0; b < CT_BANKS; b++) begin : g_bank
    ct_bank #(.LANES(LANES), .PT_W(PT_W)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en && (wr_bank == 1'(b))),
      .wr_row  (wr_row),
      .wr_data (in_slice),
      .rd_col  (rd_col),
      .rd_data (bank_rd[b])
    );
  end

  ct_reader #(.LANES(LANES)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (fill),
    .fill_bank (wr_bank),
    .rd_active (out_valid),
    .rd_col    (rd_col),
    .rd_bank   (rd_bank)
  );

  assign out_col = bank_rd[rd_bank];

  // A bank completes only when the reader is idle or on its final column.
  assert_reader_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> (!out_valid || rd_col == LAST));

  // Output starts only on the cycle after a bank completes.
  assert_valid_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fill));

  // Draining never reads the bank the writer is filling.
  assert_no_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_en && !(rd_col == LAST)) |-> (rd_bank != wr_bank));
endmodule

// File: tb/slice_corner_turn_test.sv
`timescale 1ns/1ps
module slice_corner_turn_test;
  localparam int BUS_W = 64;

  logic             clk = 1'b0;
  logic             rst_n, in_valid, in_start, out_valid;
  logic [BUS_W-1:0] in_slice, out_col;

  int errors = 0, checks = 0, pcnt = 0, ncap = 0;
  logic [BUS_W-1:0] cap_data [64];
  int               cap_cyc  [64];

  always #2 clk = ~clk;

  slice_corner_turn uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_slice(in_slice), .out_valid(out_valid), .out_col(out_col)
  );

  always @(posedge clk) pcnt <= pcnt + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && ncap < 64) begin
      cap_data[ncap] = out_col;
      cap_cyc[ncap]  = pcnt;
      ncap++;
    end
  end

  function automatic logic [7:0] pt(int seed, int s, int l);
    return 8'((s * 8 + l) + seed * 67);
  endfunction

  function automatic logic [BUS_W-1:0] slice_word(int seed, int s);
    logic [BUS_W-1:0] w;
    for (int l = 0; l < 8; l++) w[l*8 +: 8] = pt(seed, s, l);
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] col_word(int seed, int j);
    logic [BUS_W-1:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = pt(seed, k, j);
    return w;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(bit v, bit st, logic [BUS_W-1:0] d);
    @(posedge clk); #1;
    in_valid = v; in_start = st; in_slice = d;
  endtask

  task automatic idle(int n);
    repeat (n) drive(1'b0, 1'b0, '0);
  endtask

  task automatic send_frame(int seed, output int p0);
    p0 = 0;
    for (int s = 0; s < 8; s++) begin
      drive(1'b1, s == 0, slice_word(seed, s));
      if (s == 0) p0 = pcnt;
    end
  endtask

  task automatic check_frame(int base, int seed, int p0, string req);
    chk(cap_cyc[base] == p0 + 8, req, cap_cyc[base], p0 + 8);
    chk(cap_cyc[base+7] == cap_cyc[base] + 7, req, cap_cyc[base+7], cap_cyc[base] + 7);
    for (int j = 0; j < 8; j++)
      chk(cap_data[base+j] == col_word(seed, j), "R2 column data",
          cap_data[base+j], col_word(seed, j));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_slice = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(10);
    chk(ncap == 0, "R1 no output after reset", ncap, 0);
  endtask

  task automatic t_single(int seed);
    int p0;
    ncap = 0;
    send_frame(seed, p0);
    idle(12);
    chk(ncap == 8, "R3 single frame length", ncap, 8);
    check_frame(0, seed, p0, "R3 single frame timing");
  endtask

  task automatic t_back_to_back();
    int p0, p1, p2;
    ncap = 0;
    send_frame(21, p0);
    send_frame(22, p1);
    send_frame(23, p2);
    idle(12);
    chk(ncap == 24, "R4 back-to-back count", ncap, 24);
    chk(cap_cyc[23] - cap_cyc[0] == 23, "R4 unbroken run", cap_cyc[23] - cap_cyc[0], 23);
    check_frame(0, 21, p0, "R4 frame 0");
    check_frame(8, 22, p1, "R4 frame 1");
    check_frame(16, 23, p2, "R4 frame 2");
  endtask

  task automatic t_orphan();
    ncap = 0;
    for (int s = 0; s < 8; s++) drive(1'b1, 1'b0, slice_word(31, s));
    idle(12);
    chk(ncap == 0, "R5 slices without start ignored", ncap, 0);
  endtask

  task automatic t_restart();
    int p0;
    ncap = 0;
    for (int s = 0; s < 3; s++) drive(1'b1, s == 0, slice_word(41, s));
    send_frame(42, p0);
    idle(12);
    chk(ncap == 8, "R6 only restarted frame out", ncap, 8);
    check_frame(0, 42, p0, "R6 restart timing");
  endtask

  task automatic t_gap();
    int p0;
    ncap = 0;
    for (int s = 0; s < 4; s++) drive(1'b1, s == 0, slice_word(51, s));
    idle(1);
    for (int s = 4; s < 8; s++) drive(1'b1, 1'b0, slice_word(51, s));
    idle(12);
    chk(ncap == 0, "R7 gapped frame dropped", ncap, 0);
    send_frame(52, p0);
    idle(12);
    chk(ncap == 8, "R7 next frame length", ncap, 8);
    check_frame(0, 52, p0, "R7 next frame");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_single(11);
    t_single(200);
    t_back_to_back();
    t_orphan();
    t_restart();
    t_gap();
    finish_run();
  end
endmodule